// File: doc/BRIEF.md
# Dormant Mode Wake Controller

This block parks the chip in a deep sleep and brings it back. Software picks one watched input pin and one of four wake conditions, chooses which of two oscillators drives the system, and then asks for dormancy. The block drops the enable of the selected oscillator and the system clock gate together, so all gated logic halts. The block itself runs on an always-on reference clock, and that clock also times the oscillator warm-up.

Edge wake conditions are caught by an asynchronous set latch that needs no clock edge. Level wake conditions are sampled on the reference clock. Once a condition is caught, the oscillator enable returns at once. The system clock gate stays closed until a programmable warm-up count of reference cycles has run out. The caught event stays pending until software clears it, and a pending event blocks any new dormancy request.

Top module: `dormant_wake_ctrl`

## Requirements
- R1: After reset, clk_en is 1, osc_en is 2'b01, dormant is 0, wake_pending is 0, and the warm-up count is 64.
- R2: A write of bit 0 = 1 to address 2, made while running, with the wake enabled and nothing pending, sets dormant to 1 and clears clk_en and osc_en at that write's clock edge.
- R3: A dormancy request is ignored (dormant stays 0 and clk_en stays 1) while wake_pending is 1 or while the wake enable is 0.
- R4: Address 0 holds the configuration: pin index in bits [3:0], wake condition in bits [9:8] (00 level low, 01 level high, 10 rising edge, 11 falling edge), enable in bit 12 and oscillator select in bit 13. A level condition sets wake_pending at the first reference edge at which the pin matches.
- R5: An edge condition sets wake_pending as soon as the edge occurs, with no reference clock edge needed.
- R6: After a wake while dormant, the selected osc_en bit is on for the whole warm-up. clk_en returns N+1 reference edges after an edge event, or N+2 edges after a level event first matches, where N is the warm-up count.
- R7: Address 1 bits [9:0] set the warm-up count N. A value below 8 is stored as 8.
- R8: A write to address 3 with bit 0 = 1 clears wake_pending at that write's edge. The same write with bit 0 = 0 leaves it set.
- R9: Activity on any pin other than the selected one never sets wake_pending.
- R10: Configuration bit 13 selects the oscillator: 0 drives osc_en = 2'b01, 1 drives osc_en = 2'b10, and a wake restarts the selected one.
- R11: Only one wake condition is armed at a time. Writing a new condition replaces the old one, so the old condition no longer sets wake_pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 config, 1 warm-up, 2 command, 3 acknowledge) |
| wr_data | input | 16 | Register write data |
| gpio_in | input | NPIN | Watched input pins |
| clk_en | output | 1 | System clock gate enable |
| osc_en | output | 2 | Oscillator enables, one-hot or zero |
| dormant | output | 1 | High while in dormancy |
| wake_pending | output | 1 | Caught wake event awaiting acknowledge |

## Verification
Register writes take effect at the edge that samples them, so dormant, clk_en, osc_en and the acknowledge clear are all checked at the falling edge right after the write. An edge event is checked 1 ns after the pin moves, before any rising edge, and a level event is checked one edge later. For warm-up, the bench counts rising edges from the falling edge at which the event is applied until clk_en is seen high, and compares that count with N+1 for edge conditions or N+2 for level conditions, with N already clamped.

// File: rtl/dormant_wake_ctrl.sv
module dormant_wake_ctrl #(
  parameter int NPIN    = 16,
  parameter int CNTW    = 10,
  parameter int CNT_MIN = 8,
  parameter int CNT_RST = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [15:0]     wr_data,
  input  logic [NPIN-1:0] gpio_in,
  output logic            clk_en,
  output logic [1:0]      osc_en,
  output logic            dormant,
  output logic            wake_pending
);
  localparam int PW = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam logic [CNTW-1:0] CMIN = CNTW'(CNT_MIN);

  typedef enum logic [1:0] {ST_RUN, ST_DORM, ST_WARM} st_t;

  st_t            st_q;
  logic [PW-1:0]  pin_q;
  logic [1:0]     evt_q;
  logic           en_q, osc_q, lvl_q, edge_q, clr_q;
  logic [CNTW-1:0] start_q, cnt_q;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  wire wr_cfg = wr_en && (wr_addr == 2'd0);
  wire wr_cnt = wr_en && (wr_addr == 2'd1);
  wire go     = wr_en && (wr_addr == 2'd2) && wr_data[0];
  wire ack    = wr_en && (wr_addr == 2'd3) && wr_data[0];

  wire [CNTW-1:0] cnt_in = wr_data[CNTW-1:0];
  wire pin     = gpio_in[pin_q];
  wire is_edge = evt_q[1];
  wire lvl_hit = en_q && !is_edge && (pin == evt_q[0]);
  wire ev_clk  = en_q && is_edge && (evt_q[0] ? !pin : pin);
  wire edge_clr = clr_q || !rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= '0;
      evt_q   <= 2'b00;
      en_q    <= 1'b0;
      osc_q   <= 1'b0;
      start_q <= CNTW'(CNT_RST);
      clr_q   <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        pin_q <= wr_data[PW-1:0];
        evt_q <= wr_data[9:8];
        en_q  <= wr_data[12];
        osc_q <= wr_data[13];
      end
      if (wr_cnt) start_q <= (cnt_in < CMIN) ? CMIN : cnt_in;
      clr_q <= ack;
      if (ack)          lvl_q <= 1'b0;
      else if (lvl_hit) lvl_q <= 1'b1;
    end
  end

  always_ff @(posedge ev_clk or posedge edge_clr) begin
    if (edge_clr) edge_q <= 1'b0;
    else          edge_q <= 1'b1;
  end

  assign wake_pending = lvl_q | edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN:  if (go && en_q && !wake_pending) st_q <= ST_DORM;
        ST_DORM: if (wake_pending) begin
                   st_q  <= ST_WARM;
                   cnt_q <= start_q;
                 end
        ST_WARM: if (cnt_q == CNTW'(1)) st_q <= ST_RUN;
                 else                   cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign clk_en  = (st_q == ST_RUN);
  assign dormant = (st_q == ST_DORM);
  assign osc_en  = dormant ? 2'b00 : (osc_q ? 2'b10 : 2'b01);

  AST_NO_SLEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dormant) |-> !$past(wake_pending)); // R3
  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dormant) |-> $past(wake_pending)); // R6
  AST_WARM_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dormant) |-> !clk_en); // R6
  AST_OSC_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(osc_en) != 2'b00)); // R6
  AST_OSC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_en)); // R10
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    start_q >= CMIN); // R7
endmodule

// File: tb/dormant_wake_ctrl_bench.sv
module dormant_wake_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] gpio_in = '0;
  logic clk_en, dormant, wake_pending;
  logic [1:0] osc_en;
  int checks = 0, fails = 0, cyc = 0;

  dormant_wake_ctrl u_dormant_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gpio_in(gpio_in), .clk_en(clk_en), .osc_en(osc_en), .dormant(dormant),
    .wake_pending(wake_pending));

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int clamp_n(input int n);
    return (n < 8) ? 8 : n;
  endfunction
  function automatic int exp_wake(input int typ, input int n);
    return clamp_n(n) + ((typ >= 2) ? 1 : 2);
  endfunction
  function automatic logic inact(input int typ);
    return (typ == 0 || typ == 3);
  endfunction
  function automatic int exp_osc(input int sel);
    return sel ? 2 : 1;
  endfunction
  function automatic logic [15:0] cfg(input int p, input int typ, input int en, input int osc);
    return 16'(p & 15) | 16'(typ << 8) | 16'(en << 12) | 16'(osc << 13);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wake_count(output int c);
    c = 0;
    do begin
      @(posedge clk); c++;
      @(negedge clk);
    end while (!clk_en && c < 4000);
  endtask

  task automatic arm(input int p, input int typ, input int osc, input logic [15:0] others);
    wr(2'd0, 16'h0);
    gpio_in = others;
    gpio_in[p] = inact(typ);
    wr(2'd0, cfg(p, typ, 1, osc));
    wr(2'd3, 16'h1);
  endtask

  initial begin
    int c;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 dormant", dormant, 0);
    chk("R1 pending", wake_pending, 0);

    // default warm-up 64 with a rising-edge wake
    wr(2'd0, cfg(3, 2, 1, 0));
    wr(2'd2, 16'h1);
    chk("R2 dormant", dormant, 1);
    chk("R2 clk_en", clk_en, 0);
    chk("R2 osc_en", osc_en, 0);
    gpio_in[3] = 1'b1;
    #1;
    chk("R5 async pending", wake_pending, 1);
    chk("R5 still dormant", dormant, 1);
    wake_count(c);
    chk("R1 default warm-up R6", c, exp_wake(2, 64));
    chk("R10 osc after wake", osc_en, 1);

    // pending blocks dormancy; acknowledge bit rules
    wr(2'd2, 16'h1);
    chk("R3 pending blocks", dormant, 0);
    chk("R3 clk stays", clk_en, 1);
    wr(2'd3, 16'h0);
    chk("R8 ack bit0=0", wake_pending, 1);
    wr(2'd3, 16'h1);
    chk("R8 ack clears", wake_pending, 0);
    wr(2'd0, cfg(3, 2, 0, 0));
    wr(2'd2, 16'h1);
    chk("R3 disabled blocks", dormant, 0);

    // selected pin only, level high
    arm(5, 1, 1, 16'h0);
    chk("R10 osc select", osc_en, 2);
    gpio_in[4] = 1'b1; gpio_in[6] = 1'b1; gpio_in[15] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 other pins", wake_pending, 0);
    gpio_in[5] = 1'b1;
    #1;
    chk("R4 level not yet", wake_pending, 0);
    @(negedge clk);
    chk("R4 level high", wake_pending, 1);

    // replace condition with falling edge on same pin, pin held high
    wr(2'd0, cfg(5, 3, 1, 1));
    wr(2'd3, 16'h1);
    repeat (3) @(negedge clk);
    chk("R11 old level gone", wake_pending, 0);
    gpio_in[5] = 1'b0;
    #1;
    chk("R11 new falling", wake_pending, 1);

    // clamp of a short warm-up, level low
    wr(2'd1, 16'd3);
    arm(2, 0, 0, 16'h0);
    wr(2'd2, 16'h1);
    chk("R2 dormant lvl", dormant, 1);
    gpio_in[2] = 1'b0;
    wake_count(c);
    chk("R7 clamp to 8", c, exp_wake(0, 3));
    gpio_in[2] = 1'b1;
    wr(2'd3, 16'h1);

    for (int i = 0; i < 24; i++) begin
      int p, typ, n, osc;
      p = int'($urandom % 16); typ = int'($urandom % 4);
      n = 1 + int'($urandom % 40); osc = int'($urandom % 2);
      wr(2'd1, 16'(n));
      arm(p, typ, osc, 16'($urandom));
      chk("R8 clean start", wake_pending, 0);
      wr(2'd2, 16'h1);
      chk("R2 rnd dormant", dormant, 1);
      chk("R2 rnd osc off", osc_en, 0);
      for (int k = 0; k < 3; k++) begin
        logic [15:0] r;
        @(negedge clk);
        r = 16'($urandom);
        r[p] = inact(typ);
        gpio_in = r;
      end
      @(negedge clk);
      chk("R9 rnd others", dormant, 1);
      gpio_in[p] = ~inact(typ);
      wake_count(c);
      chk("R6 rnd warm-up", c, exp_wake(typ, n));
      chk("R10 rnd osc", osc_en, exp_osc(osc));
      gpio_in[p] = inact(typ);
      wr(2'd3, 16'h1);
      chk("R8 rnd ack", wake_pending, 0);
    end
    finish_run();
  end
endmodule